// File: doc/BRIEF.md
# Host Bus Word Packing Engine

This block sits between a narrow external host data path and a wider internal bus. On writes it collects a short series of host data accesses, one to four of them, into one internal word. It issues a single internal write only after every byte that the configured word size needs has arrived. On reads, the first host access of a packet fetches one internal word. That access and the ones after it each return one host-sized slice of the fetched word.

The host path can be 8 or 16 bits wide and the internal word can be 16 or 24 bits. For 24-bit words on an 8-bit path, a further option adds a fourth access that carries only padding. Another option selects whether the most significant byte travels first. An address phase from the host marks the start of a new packet. If that phase arrives while a packet is only partly transferred, the partial bytes are dropped and a one-cycle flag reports the abort. Address decoding, address generation and arbitration are handled elsewhere.

Top module: `host_pack_engine`

## Requirements
- R1: A packet is 2 accesses for an 8-bit path with 16-bit words, 3 for an 8-bit path with 24-bit words (4 when `cfg_pad4`=1), 1 for a 16-bit path with 16-bit words, and 2 for a 16-bit path with 24-bit words. `bus_req` rises in the cycle after the last write access of a packet is accepted, and never after an earlier one.
- R2: On an 8-bit path (`cfg_bus16`=0) each access carries one byte in `h_wdata[7:0]` / `h_rdata[7:0]`. `h_wdata[15:8]` is ignored and `h_rdata[15:8]` reads 0. With `cfg_big`=0, access k carries byte k, counted from the least significant byte. With `cfg_big`=1 the byte order is reversed, so the most significant byte travels first.
- R3: On a 16-bit path the first access carries word bits 15:0. With `cfg_big`=0, bits 7:0 sit on lane 7:0. With `cfg_big`=1 the two byte lanes are swapped.
- R4: On a 16-bit path with 24-bit words, the second access carries word bits 23:16 in its low byte. Its high byte is ignored on writes and reads as 0.
- R5: When `cfg_pad4`=1 on an 8-bit path with 24-bit words, the fourth access is padding. Its write data is discarded and its read data is 0.
- R6: With 16-bit words (`cfg_word24`=0), `bus_wdata[23:16]` is 0 and `bus_rdata[23:16]` is ignored.
- R7: While `bus_req`=1 and `bus_ready`=0, `bus_req`, `bus_we` and `bus_wdata` hold steady. A transfer happens on a clock edge where both are 1, and `bus_req` is 0 in the next cycle.
- R8: The first read access of a packet raises `bus_req` with `bus_we`=0. In the cycle after the transfer edge, `h_rvalid` pulses with slice 0. Each later read access of the packet gives `h_rvalid` with its slice in the next cycle, taken from the held word, and makes no internal request.
- R9: An accepted `h_addr_phase` in the middle of a packet discards the partial packet and pulses `pkt_abort` for one cycle in the next cycle. The next access starts a new packet. An address phase between packets gives no abort.
- R10: While `h_busy`=1, host strobes and address phases are ignored.
- R11: In the middle of a packet, a strobe in the direction opposite to the packet's first access is ignored.
- R12: After reset, `bus_req`, `h_busy`, `h_rvalid` and `pkt_abort` are 0 and `h_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bus16 | input | 1 | 1: 16-bit host path, 0: 8-bit |
| cfg_word24 | input | 1 | 1: 24-bit internal word, 0: 16-bit |
| cfg_pad4 | input | 1 | 1: four-access packing for 24-bit words on an 8-bit path |
| cfg_big | input | 1 | 1: most significant byte first |
| h_addr_phase | input | 1 | Host address phase, starts a new packet |
| h_wr_stb | input | 1 | Host write data access, one cycle |
| h_rd_stb | input | 1 | Host read data access, one cycle |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read slice |
| h_rvalid | output | 1 | Read slice valid, one cycle |
| h_busy | output | 1 | Internal transfer pending; host must wait |
| pkt_abort | output | 1 | Partial packet discarded |
| bus_req | output | 1 | Internal request |
| bus_we | output | 1 | Internal request is a write |
| bus_wdata | output | 24 | Internal write word |
| bus_ready | input | 1 | Internal bus accepts the request |
| bus_rdata | input | 24 | Internal read word, sampled on the transfer edge |

## Verification
The bench walks every combination of path width, word size, padding and byte order in both directions. It places garbage in the ignored high bytes, so a design with a lane reversed or a byte misplaced returns the wrong word or slice, and one that counts accesses wrongly raises `bus_req` early or late. Directed cases cover the following. A strobe sent while busy must not be taken as the next packet's first byte. An address phase in the middle of a packet must flag an abort and restart the byte count, while one at a packet boundary must not. A write strobe in the middle of a read packet must neither advance the read nor start a request. The padding access must neither overwrite a real byte nor return nonzero data.

// File: rtl/host_pack_engine.sv
module host_pack_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_bus16,
  input  logic        cfg_word24,
  input  logic        cfg_pad4,
  input  logic        cfg_big,
  input  logic        h_addr_phase,
  input  logic        h_wr_stb,
  input  logic        h_rd_stb,
  input  logic [15:0] h_wdata,
  output logic [15:0] h_rdata,
  output logic        h_rvalid,
  output logic        h_busy,
  output logic        pkt_abort,
  output logic        bus_req,
  output logic        bus_we,
  output logic [23:0] bus_wdata,
  input  logic        bus_ready,
  input  logic [23:0] bus_rdata
);

  logic [1:0] idx;
  logic       rd_dir;
  logic [7:0] byt [3];
  logic [7:0] nx  [3];
  logic [2:0] nacc;
  logic [1:0] nbytes;
  logic [1:0] bsel;
  logic       last;
  logic       last0;
  logic       wr_ok, rd_ok;
  logic [15:0] piece_fetch, piece_buf;

  assign h_busy = bus_req;
  assign nbytes = cfg_word24 ? 2'd3 : 2'd2;
  assign nacc   = cfg_bus16 ? (cfg_word24 ? 3'd2 : 3'd1)
                            : (cfg_word24 ? (cfg_pad4 ? 3'd4 : 3'd3) : 3'd2);
  assign last   = ({1'b0, idx} == (nacc - 3'd1));
  assign last0  = (nacc == 3'd1);
  assign bsel   = cfg_big ? 2'(nbytes - 2'd1 - idx) : idx;
  assign wr_ok  = h_wr_stb && !(idx != 2'd0 && rd_dir);
  assign rd_ok  = h_rd_stb && !(idx != 2'd0 && !rd_dir);

  function automatic logic [15:0] slice(input logic [23:0] w, input logic [1:0] i,
                                        input logic b16, input logic w24, input logic big);
    logic [1:0] nb;
    logic [1:0] s;
    logic [23:0] wm;
    wm = w24 ? w : {8'h00, w[15:0]};
    nb = w24 ? 2'd3 : 2'd2;
    s  = big ? 2'(nb - 2'd1 - i) : i;
    if (b16) begin
      if (i == 2'd0) slice = big ? {wm[7:0], wm[15:8]} : wm[15:0];
      else           slice = {8'h00, wm[23:16]};
    end else if (i >= nb) begin
      slice = 16'h0000;
    end else begin
      case (s)
        2'd0:    slice = {8'h00, wm[7:0]};
        2'd1:    slice = {8'h00, wm[15:8]};
        default: slice = {8'h00, wm[23:16]};
      endcase
    end
  endfunction

  assign piece_fetch = slice(bus_rdata, 2'd0, cfg_bus16, cfg_word24, cfg_big);
  assign piece_buf   = slice({byt[2], byt[1], byt[0]}, idx, cfg_bus16, cfg_word24, cfg_big);

  always_comb begin
    nx[0] = byt[0];
    nx[1] = byt[1];
    nx[2] = byt[2];
    if (cfg_bus16) begin
      if (idx == 2'd0) begin
        nx[0] = cfg_big ? h_wdata[15:8] : h_wdata[7:0];
        nx[1] = cfg_big ? h_wdata[7:0]  : h_wdata[15:8];
      end else begin
        nx[2] = h_wdata[7:0];
      end
    end else if (idx < nbytes) begin
      nx[bsel] = h_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= 2'd0;
      rd_dir    <= 1'b0;
      byt       <= '{default: 8'h00};
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_wdata <= 24'h0;
      h_rdata   <= 16'h0;
      h_rvalid  <= 1'b0;
      pkt_abort <= 1'b0;
    end else begin
      h_rvalid  <= 1'b0;
      pkt_abort <= 1'b0;
      if (bus_req) begin
        if (bus_ready) begin
          bus_req <= 1'b0;
          if (!bus_we) begin
            byt[0]   <= bus_rdata[7:0];
            byt[1]   <= bus_rdata[15:8];
            byt[2]   <= cfg_word24 ? bus_rdata[23:16] : 8'h00;
            h_rdata  <= piece_fetch;
            h_rvalid <= 1'b1;
            idx      <= last0 ? 2'd0 : 2'd1;
          end
        end
      end else if (h_addr_phase) begin
        if (idx != 2'd0) pkt_abort <= 1'b1;
        idx <= 2'd0;
      end else if (wr_ok) begin
        rd_dir <= 1'b0;
        byt    <= nx;
        if (last) begin
          idx       <= 2'd0;
          bus_req   <= 1'b1;
          bus_we    <= 1'b1;
          bus_wdata <= {cfg_word24 ? nx[2] : 8'h00, nx[1], nx[0]};
        end else begin
          idx <= idx + 2'd1;
        end
      end else if (rd_ok) begin
        rd_dir <= 1'b1;
        if (idx == 2'd0) begin
          bus_req <= 1'b1;
          bus_we  <= 1'b0;
        end else begin
          h_rvalid <= 1'b1;
          h_rdata  <= piece_buf;
          idx      <= last ? 2'd0 : idx + 2'd1;
        end
      end
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ready |=> bus_req && $stable(bus_we) && $stable(bus_wdata));

  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ready |=> !bus_req);

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && !cfg_word24 |-> bus_wdata[23:16] == 8'h00);

  p_abort_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_abort |=> !pkt_abort);

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_abort |-> !bus_req);

  p_rvalid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    h_rvalid |-> !bus_req);

  p_narrow_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    h_rvalid && !cfg_bus16 |-> h_rdata[15:8] == 8'h00);

endmodule

// File: tb/host_pack_engine_tb.sv
module host_pack_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_bus16 = 1'b0, cfg_word24 = 1'b0, cfg_pad4 = 1'b0, cfg_big = 1'b0;
  logic        h_addr_phase = 1'b0, h_wr_stb = 1'b0, h_rd_stb = 1'b0;
  logic [15:0] h_wdata = 16'h0;
  logic [15:0] h_rdata;
  logic        h_rvalid, h_busy, pkt_abort, bus_req, bus_we;
  logic [23:0] bus_wdata;
  logic        bus_ready = 1'b0;
  logic [23:0] bus_rdata = 24'h0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  host_pack_engine u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_bus16(cfg_bus16), .cfg_word24(cfg_word24), .cfg_pad4(cfg_pad4), .cfg_big(cfg_big),
    .h_addr_phase(h_addr_phase), .h_wr_stb(h_wr_stb), .h_rd_stb(h_rd_stb),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_rvalid(h_rvalid), .h_busy(h_busy),
    .pkt_abort(pkt_abort), .bus_req(bus_req), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata)
  );

  // {cfg(bus16,word24,pad4,big), wd0..wd3, expected write word, read word, slices 0..3}
  localparam logic [179:0] VEC [10] = '{
    {4'b0000, 16'hAA34, 16'hBB12, 16'h0, 16'h0, 24'h001234, 24'h77ABCD, 16'h00CD, 16'h00AB, 16'h0, 16'h0},
    {4'b0001, 16'h0012, 16'h0034, 16'h0, 16'h0, 24'h001234, 24'h00ABCD, 16'h00AB, 16'h00CD, 16'h0, 16'h0},
    {4'b0100, 16'h0056, 16'h0034, 16'h0012, 16'h0, 24'h123456, 24'hA1B2C3, 16'h00C3, 16'h00B2, 16'h00A1, 16'h0},
    {4'b0101, 16'h0012, 16'h0034, 16'h0056, 16'h0, 24'h123456, 24'hA1B2C3, 16'h00A1, 16'h00B2, 16'h00C3, 16'h0},
    {4'b0110, 16'h0056, 16'h0034, 16'h0012, 16'h00FF, 24'h123456, 24'hA1B2C3, 16'h00C3, 16'h00B2, 16'h00A1, 16'h0000},
    {4'b0111, 16'h0012, 16'h0034, 16'h0056, 16'h00EE, 24'h123456, 24'hA1B2C3, 16'h00A1, 16'h00B2, 16'h00C3, 16'h0000},
    {4'b1000, 16'h1234, 16'h0, 16'h0, 16'h0, 24'h001234, 24'h99ABCD, 16'hABCD, 16'h0, 16'h0, 16'h0},
    {4'b1001, 16'h3412, 16'h0, 16'h0, 16'h0, 24'h001234, 24'h99ABCD, 16'hCDAB, 16'h0, 16'h0, 16'h0},
    {4'b1100, 16'h3456, 16'hFF12, 16'h0, 16'h0, 24'h123456, 24'hA1B2C3, 16'hB2C3, 16'h00A1, 16'h0, 16'h0},
    {4'b1101, 16'h5634, 16'hEE12, 16'h0, 16'h0, 24'h123456, 24'hA1B2C3, 16'hC3B2, 16'h00A1, 16'h0, 16'h0}
  };

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int n_of(input logic [3:0] c);
    if (c[3]) return c[2] ? 2 : 1;
    return c[2] ? (c[1] ? 4 : 3) : 2;
  endfunction

  task automatic wr(input logic [15:0] d);
    @(negedge clk); h_wr_stb = 1'b1; h_wdata = d;
    @(negedge clk); h_wr_stb = 1'b0;
  endtask

  task automatic rd;
    @(negedge clk); h_rd_stb = 1'b1;
    @(negedge clk); h_rd_stb = 1'b0;
  endtask

  task automatic grant(input logic [23:0] rdw);
    bus_rdata = rdw; bus_ready = 1'b1;
    @(negedge clk); bus_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 24'h1, 24'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!bus_req && !h_busy && !h_rvalid && !pkt_abort && h_rdata == 16'h0, "R12",
          {h_rdata, 4'h0, bus_req, h_busy, h_rvalid, pkt_abort}, 24'h0);
    rst_n = 1'b1;

    for (int v = 0; v < 10; v++) begin
      logic [179:0] e;
      int n;
      e = VEC[v];
      {cfg_bus16, cfg_word24, cfg_pad4, cfg_big} = e[179:176];
      n = n_of(e[179:176]);
      for (int k = 0; k < n; k++) begin
        wr(e[175 - 16*k -: 16]);
        // R1: request only after the last access
        check(bus_req == (k == n - 1), "R1 access count", {23'h0, bus_req}, {23'h0, k == n - 1});
      end
      check(bus_we && bus_wdata == e[111:88], "R2/R3/R4/R5/R6 write word", bus_wdata, e[111:88]);
      grant(24'h0);
      check(!bus_req, "R7 drop after transfer", {23'h0, bus_req}, 24'h0);
      rd;
      check(bus_req && !bus_we, "R8 fetch request", {22'h0, bus_req, bus_we}, 24'h2);
      grant(e[87:64]);
      check(h_rvalid && h_rdata == e[63:48], "R8 slice 0", {8'h0, h_rdata}, {8'h0, e[63:48]});
      for (int k = 1; k < n; k++) begin
        rd;
        check(h_rvalid && !bus_req && h_rdata == e[63 - 16*k -: 16], "R2/R4/R5 read slice",
              {8'h0, h_rdata}, {8'h0, e[63 - 16*k -: 16]});
      end
    end

    // R7 / R10: hold while busy, strobe while busy ignored
    {cfg_bus16, cfg_word24, cfg_pad4, cfg_big} = 4'b0000;
    wr(16'h0011); wr(16'h0022);
    @(negedge clk); h_wr_stb = 1'b1; h_wdata = 16'h0099; h_addr_phase = 1'b1;
    @(negedge clk); h_wr_stb = 1'b0; h_addr_phase = 1'b0;
    check(bus_req && bus_wdata == 24'h002211 && !pkt_abort, "R7 hold while not ready", bus_wdata, 24'h002211);
    grant(24'h0);
    wr(16'h0033);
    check(!bus_req, "R10 busy strobe ignored", {23'h0, bus_req}, 24'h0);
    wr(16'h0044);
    check(bus_req && bus_wdata == 24'h004433, "R10 next packet", bus_wdata, 24'h004433);
    grant(24'h0);

    // R9 abort mid-packet
    wr(16'h0055);
    @(negedge clk); h_addr_phase = 1'b1;
    @(negedge clk); h_addr_phase = 1'b0;
    check(pkt_abort, "R9 abort flag", {23'h0, pkt_abort}, 24'h1);
    @(negedge clk);
    check(!pkt_abort, "R9 abort one cycle", {23'h0, pkt_abort}, 24'h0);
    wr(16'h0066);
    check(!bus_req, "R9 restart count", {23'h0, bus_req}, 24'h0);
    wr(16'h0077);
    check(bus_req && bus_wdata == 24'h007766, "R9 new packet word", bus_wdata, 24'h007766);
    grant(24'h0);
    @(negedge clk); h_addr_phase = 1'b1;
    @(negedge clk); h_addr_phase = 1'b0;
    check(!pkt_abort, "R9 boundary no abort", {23'h0, pkt_abort}, 24'h0);

    // R11 opposite direction mid-packet
    rd;
    grant(24'h00BEEF);
    check(h_rvalid && h_rdata == 16'h00EF, "R11 first slice", {8'h0, h_rdata}, 24'h0000EF);
    wr(16'h0012);
    check(!bus_req && !h_rvalid, "R11 write ignored", {22'h0, bus_req, h_rvalid}, 24'h0);
    rd;
    check(h_rvalid && h_rdata == 16'h00BE, "R11 read continues", {8'h0, h_rdata}, 24'h0000BE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule